// File: doc/BRIEF.md
# Variable-Precision Multiply-Accumulate Slice

This block is one arithmetic slice that a static mode input divides into one, two or three multiplier lanes. The widest arrangement forms a single signed 27x27 product and feeds it to a 64-bit accumulator. The middle arrangement forms two independent 18x19 products, each kept to its full 37 bits. The narrowest forms three independent 9x9 products of 18 bits each. In front of the multipliers, a pre-adder can build the 19-bit or 27-bit operand as the sum or difference of two inputs. Two small coefficient banks can replace the other operand with a stored constant that a per-lane index selects.

Each operand group can pass through an input register or skip it. An elaboration parameter fixes that choice for each group. The only other pipeline stage is the result register. A second register keeps the result from two steps back, so the accumulator can run two interleaved sums on alternate cycles. A clock enable freezes every pipeline register. The coefficient banks are loaded through a separate write port while no vectors are in flight.

Top module: `vp_mac_slice`

## Requirements
- R1: While `rst_n` is low, `res_o` is all zeros, and the result register, history register, input registers and both coefficient banks are cleared.
- R2: With `mode` = 0 (or 3), `res_o[63:0]` is the signed product of `x_in[26:0]` and `y_in[26:0]`, each taken as 27-bit two's complement, sign-extended to 64 bits (plus any accumulation), and `res_o[73:64]` is zero.
- R3: With `mode` = 1, lane i (i = 0, 1) multiplies `x_in[18i+17:18i]` (two's complement when `x_signed` = 1, unsigned otherwise) by the signed 19-bit `y_in[19i+18:19i]`, and the full 37-bit product appears on `res_o[37i+36:37i]`.
- R4: With `mode` = 2, lane k (k = 0..2) multiplies `x_in[9k+8:9k]` (signed when `x_signed` = 1) by the signed 9-bit `y_in[9k+8:9k]`, puts the 18-bit product on `res_o[18k+17:18k]`, and holds `res_o[73:54]` at zero.
- R5: With `pre_en` = 1, the y operand is built from two signed inputs: in mode 0 it is `y_in[25:0]` plus `z_in[25:0]` (26-bit), and in mode 1 lane i it is `y_in[19i+17:19i]` plus `z_in[18i+17:18i]` (18-bit). When `pre_sub` = 1 the z input is subtracted instead of added. In mode 2 the pre-adder has no effect.
- R6: With `coef_en` = 1, the x operand comes from the coefficient banks. In mode 0 it is bank 0 entry `coef_sel0` (27 bits). In mode 1 lane 0 uses bits [17:0] of bank 0 entry `coef_sel0`, and lane 1 uses bank 1 entry `coef_sel1`. A write with `cw_en` = 1 stores `cw_data` (bank 0, 27 bits) or `cw_data[17:0]` (bank 1, when `cw_bank` = 1) at `cw_addr`. In mode 2 the banks have no effect.
- R7: In mode 0, `acc_en` = 0 loads the new product into the result, and `acc_en` = 1 adds it to the most recent result.
- R8: The 64-bit accumulation wraps modulo 2^64.
- R9: With `acc_en` = 1 and `acc_dbl` = 1, the product is added to the result from two updates earlier, so two independent sums can be interleaved.
- R10: With all input registers in use, a vector reaches `res_o` two clock cycles after it is applied. With all of them bypassed it takes one cycle. Each bypassed group removes one cycle from its own path.
- R11: While `ce` is low, `res_o` and all pipeline state hold their values, and the data and control inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low clear |
| ce | input | 1 | Clock enable for all pipeline registers |
| mode | input | 2 | Static arrangement: 0 one 27x27, 1 two 18x19, 2 three 9x9 |
| x_signed | input | 1 | Static: x operands are signed in modes 1 and 2 |
| pre_en | input | 1 | Static: enable the pre-adder on the y operand |
| coef_en | input | 1 | Static: take the x operand from the coefficient banks |
| pre_sub | input | 1 | Pre-adder subtracts z when high |
| coef_sel0 | input | SW | Bank 0 index (lane 0 / wide lane) |
| coef_sel1 | input | SW | Bank 1 index (lane 1) |
| acc_en | input | 1 | Accumulate rather than load (mode 0) |
| acc_dbl | input | 1 | Accumulate onto the result from two updates back |
| x_in | input | 36 | Packed x operands |
| y_in | input | 38 | Packed y operands |
| z_in | input | 36 | Packed pre-adder second operands |
| cw_en | input | 1 | Coefficient write strobe |
| cw_bank | input | 1 | Coefficient bank select for writes |
| cw_addr | input | SW | Coefficient write index |
| cw_data | input | 27 | Coefficient write data |
| res_o | output | 74 | Registered packed results |

## Verification
The bench builds two copies side by side with the default bank depth of eight. One copy keeps every input register, and the other bypasses them all, so each vector is checked against the same arithmetic expectation at both latencies. The three-lane arrangement is small enough to sweep every pair of 9-bit operands. The wider arrangements get random operands plus the signed extremes, every pre-adder and coefficient setting, and accumulation runs that include a full wrap of the 64-bit sum.

// File: rtl/vp_mac_slice.sv
module vp_mac_slice #(
  parameter bit IN_REG_X   = 1'b1,
  parameter bit IN_REG_Y   = 1'b1,
  parameter bit IN_REG_CTL = 1'b1,
  parameter int BANK_DEPTH = 8,
  localparam int SW = $clog2(BANK_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic [1:0]    mode,
  input  logic          x_signed,
  input  logic          pre_en,
  input  logic          coef_en,
  input  logic          pre_sub,
  input  logic [SW-1:0] coef_sel0,
  input  logic [SW-1:0] coef_sel1,
  input  logic          acc_en,
  input  logic          acc_dbl,
  input  logic [35:0]   x_in,
  input  logic [37:0]   y_in,
  input  logic [35:0]   z_in,
  input  logic          cw_en,
  input  logic          cw_bank,
  input  logic [SW-1:0] cw_addr,
  input  logic [26:0]   cw_data,
  output logic [73:0]   res_o
);
  localparam logic [1:0] M_DUAL = 2'd1, M_TRIPLE = 2'd2;

  logic [35:0]   x_q, z_q, xs, zs;
  logic [37:0]   y_q, ys;
  logic [SW-1:0] s0_q, s1_q, s0, s1;
  logic          sub_q, acc_q, dbl_q, sub_s, acc_s, dbl_s;
  logic [26:0]   bank0 [BANK_DEPTH];
  logic [17:0]   bank1 [BANK_DEPTH];
  logic [73:0]   res_q, nxt, dual_w;
  logic [53:0]   tri_w;
  logic [63:0]   prev_q, fb;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      x_q <= '0; y_q <= '0; z_q <= '0; s0_q <= '0; s1_q <= '0;
      sub_q <= 1'b0; acc_q <= 1'b0; dbl_q <= 1'b0;
      res_q <= '0; prev_q <= '0;
    end else if (ce) begin
      x_q <= x_in; y_q <= y_in; z_q <= z_in;
      s0_q <= coef_sel0; s1_q <= coef_sel1;
      sub_q <= pre_sub; acc_q <= acc_en; dbl_q <= acc_dbl;
      res_q <= nxt; prev_q <= res_q[63:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < BANK_DEPTH; i++) begin
        bank0[i] <= '0;
        bank1[i] <= '0;
      end
    end else if (cw_en) begin
      if (cw_bank) bank1[cw_addr] <= cw_data[17:0];
      else         bank0[cw_addr] <= cw_data;
    end

  assign xs    = IN_REG_X   ? x_q   : x_in;
  assign s0    = IN_REG_X   ? s0_q  : coef_sel0;
  assign s1    = IN_REG_X   ? s1_q  : coef_sel1;
  assign ys    = IN_REG_Y   ? y_q   : y_in;
  assign zs    = IN_REG_Y   ? z_q   : z_in;
  assign sub_s = IN_REG_Y   ? sub_q : pre_sub;
  assign acc_s = IN_REG_CTL ? acc_q : acc_en;
  assign dbl_s = IN_REG_CTL ? dbl_q : acc_dbl;

  logic signed [26:0] fx, fy;
  logic signed [53:0] fp;
  assign fx = coef_en ? bank0[s0] : xs[26:0];
  assign fy = !pre_en ? ys[26:0]
            : sub_s   ? {ys[25], ys[25:0]} - {zs[25], zs[25:0]}
                      : {ys[25], ys[25:0]} + {zs[25], zs[25:0]};
  assign fp = 54'(fx) * 54'(fy);

  for (genvar i = 0; i < 2; i++) begin : g_dual
    logic [17:0]        cx, ya, za;
    logic signed [18:0] dx, dy;
    logic signed [36:0] dp;
    assign cx = coef_en ? (i == 0 ? bank0[s0][17:0] : bank1[s1]) : xs[18*i +: 18];
    assign ya = ys[19*i +: 18];
    assign za = zs[18*i +: 18];
    assign dx = {x_signed & cx[17], cx};
    assign dy = !pre_en ? ys[19*i +: 19]
              : sub_s   ? {ya[17], ya} - {za[17], za}
                        : {ya[17], ya} + {za[17], za};
    assign dp = 37'(dx) * 37'(dy);
    assign dual_w[37*i +: 37] = dp;
  end

  for (genvar k = 0; k < 3; k++) begin : g_tri
    logic signed [9:0]  tx;
    logic signed [8:0]  ty;
    logic signed [17:0] tp;
    assign tx = {x_signed & xs[9*k+8], xs[9*k +: 9]};
    assign ty = ys[9*k +: 9];
    assign tp = 18'(tx) * 18'(ty);
    assign tri_w[18*k +: 18] = tp;
  end

  assign fb = !acc_s ? 64'd0 : dbl_s ? prev_q : res_q[63:0];

  always_comb
    case (mode)
      M_DUAL:   nxt = dual_w;
      M_TRIPLE: nxt = {20'd0, tri_w};
      default:  nxt = {10'd0, {{10{fp[53]}}, fp} + fb};
    endcase

  assign res_o = res_q;
endmodule

// File: rtl/vp_mac_slice_chk.sv
module vp_mac_slice_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ce,
  input logic [1:0]  mode,
  input logic [73:0] res_o
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> res_o == '0);

  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(res_o));

  assert_wide_top_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && mode == 2'd0) |=> res_o[73:64] == '0);

  assert_narrow_top_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && mode == 2'd2) |=> res_o[73:54] == '0);
endmodule

bind vp_mac_slice vp_mac_slice_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ce(ce), .mode(mode), .res_o(res_o)
);

// File: tb/vp_mac_slice_tb_top.sv
module vp_mac_slice_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, ce = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        x_signed = 1'b1, pre_en = 1'b0, coef_en = 1'b0, pre_sub = 1'b0;
  logic [2:0]  coef_sel0 = '0, coef_sel1 = '0, cw_addr = '0;
  logic        acc_en = 1'b0, acc_dbl = 1'b0, cw_en = 1'b0, cw_bank = 1'b0;
  logic [35:0] x_in = '0, z_in = '0;
  logic [37:0] y_in = '0;
  logic [26:0] cw_data = '0;
  logic [73:0] res_m, res_b;

  vp_mac_slice dut_i (.*, .res_o(res_m));
  vp_mac_slice #(.IN_REG_X(1'b0), .IN_REG_Y(1'b0), .IN_REG_CTL(1'b0)) dut_byp_i (.*, .res_o(res_b));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [73:0] e1 = '0, e2 = '0;
  logic v1 = 1'b0, v2 = 1'b0;
  string t1 = "", t2 = "";
  logic [26:0] b0m [8];
  logic [17:0] b1m [8];
  logic [63:0] m1 = '0, m2 = '0;
  localparam logic [26:0] MIN27 = 27'h4000000, MAX27 = 27'h3ffffff;

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog: got no completion, expected end of run");
    finish_up();
  end

  task automatic check(input logic [73:0] act, input logic [73:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd();
    return {$urandom(), $urandom()};
  endfunction

  function automatic longint sx(input logic [63:0] v, input int w);
    longint t;
    t = longint'(v << (64 - w));
    return t >>> (64 - w);
  endfunction

  function automatic logic [73:0] model();
    logic [73:0] r;
    longint xa, ya, p;
    logic [63:0] fbv;
    r = '0;
    case (mode)
      2'd1: for (int i = 0; i < 2; i++) begin
        logic [17:0] xv;
        xv = coef_en ? (i == 0 ? b0m[coef_sel0][17:0] : b1m[coef_sel1]) : x_in[18*i +: 18];
        xa = x_signed ? sx(64'(xv), 18) : longint'(xv);
        if (!pre_en) ya = sx(64'(y_in[19*i +: 19]), 19);
        else if (pre_sub) ya = sx(64'(y_in[19*i +: 18]), 18) - sx(64'(z_in[18*i +: 18]), 18);
        else ya = sx(64'(y_in[19*i +: 18]), 18) + sx(64'(z_in[18*i +: 18]), 18);
        p = xa * ya;
        r[37*i +: 37] = p[36:0];
      end
      2'd2: for (int k = 0; k < 3; k++) begin
        logic [8:0] xv;
        xv = x_in[9*k +: 9];
        xa = x_signed ? sx(64'(xv), 9) : longint'(xv);
        ya = sx(64'(y_in[9*k +: 9]), 9);
        p = xa * ya;
        r[18*k +: 18] = p[17:0];
      end
      default: begin
        logic [26:0] xv;
        xv = coef_en ? b0m[coef_sel0] : x_in[26:0];
        xa = sx(64'(xv), 27);
        if (!pre_en) ya = sx(64'(y_in[26:0]), 27);
        else if (pre_sub) ya = sx(64'(y_in[25:0]), 26) - sx(64'(z_in[25:0]), 26);
        else ya = sx(64'(y_in[25:0]), 26) + sx(64'(z_in[25:0]), 26);
        p = xa * ya;
        fbv = !acc_en ? 64'd0 : acc_dbl ? m2 : m1;
        r = {10'd0, 64'(p) + fbv};
      end
    endcase
    return r;
  endfunction

  task automatic tick();
    @(negedge clk);
    if (v2) check(res_m, e2, {t2, " registered"});
    if (v1) check(res_b, e1, {t1, " bypassed"});
    e2 = e1; v2 = v1; t2 = t1; v1 = 1'b0;
  endtask

  task automatic expect1(input string tag);
    logic [73:0] e;
    e = model();
    m2 = m1; m1 = e[63:0];
    e1 = e; v1 = 1'b1; t1 = tag;
  endtask

  task automatic flush();
    tick(); tick();
  endtask

  task automatic wr_coef(input logic bank, input logic [2:0] addr, input logic [26:0] d);
    @(negedge clk);
    cw_en = 1'b1; cw_bank = bank; cw_addr = addr; cw_data = d;
    if (bank) b1m[addr] = d[17:0]; else b0m[addr] = d;
    @(negedge clk);
    cw_en = 1'b0;
  endtask

  task automatic run_full(input int n, input logic pe, input logic cc, input int accm, input string tag);
    mode = 2'd0; pre_en = pe; coef_en = cc;
    for (int i = 0; i < n; i++) begin
      tick();
      x_in = 36'(rnd()); y_in = 38'(rnd()); z_in = 36'(rnd());
      pre_sub = 1'($urandom()); coef_sel0 = 3'($urandom()); coef_sel1 = 3'($urandom());
      if (i < 4) begin
        x_in[26:0] = i[0] ? MAX27 : MIN27;
        y_in[26:0] = i[1] ? MAX27 : MIN27;
        z_in[25:0] = i[0] ? 26'h1ffffff : 26'h2000000;
      end
      acc_en  = (i >= 2 && accm > 0) ? ($urandom() % 4 != 0) : 1'b0;
      acc_dbl = (i >= 2 && accm == 2) ? 1'($urandom()) : 1'b0;
      expect1(tag);
    end
    flush();
  endtask

  task automatic run_dual(input int n, input logic xsg, input logic pe, input logic cc, input string tag);
    mode = 2'd1; x_signed = xsg; pre_en = pe; coef_en = cc; acc_en = 1'b0; acc_dbl = 1'b0;
    for (int i = 0; i < n; i++) begin
      tick();
      x_in = 36'(rnd()); y_in = 38'(rnd()); z_in = 36'(rnd());
      pre_sub = 1'($urandom()); coef_sel0 = 3'($urandom()); coef_sel1 = 3'($urandom());
      if (i < 4) begin
        x_in = i[0] ? {18'h1ffff, 18'h20000} : {18'h20000, 18'h1ffff};
        y_in = i[1] ? {19'h3ffff, 19'h40000} : {19'h40000, 19'h3ffff};
        z_in = i[0] ? {18'h20000, 18'h20000} : {18'h1ffff, 18'h1ffff};
      end
      expect1(tag);
    end
    flush();
  endtask

  task automatic run_tri(input int n, input logic xsg, input logic pe, input logic cc, input string tag);
    mode = 2'd2; x_signed = xsg; pre_en = pe; coef_en = cc;
    for (int i = 0; i < n; i++) begin
      tick();
      x_in = 36'(rnd()); y_in = 38'(rnd()); z_in = 36'(rnd());
      pre_sub = 1'($urandom()); coef_sel0 = 3'($urandom()); coef_sel1 = 3'($urandom());
      acc_en = 1'($urandom()); acc_dbl = 1'($urandom());
      expect1(tag);
    end
    flush();
  endtask

  initial begin
    logic [73:0] snap_m, snap_b;
    for (int i = 0; i < 8; i++) begin b0m[i] = '0; b1m[i] = '0; end
    repeat (3) @(negedge clk);
    check(res_m, 74'd0, "R1 registered copy in reset");
    check(res_b, 74'd0, "R1 bypassed copy in reset");
    rst_n = 1'b1; ce = 1'b1;
    @(negedge clk);
    check(res_m, 74'd0, "R1 registered copy after release");

    for (int i = 0; i < 8; i++) begin
      wr_coef(1'b0, 3'(i), i == 0 ? MIN27 : i == 7 ? MAX27 : 27'($urandom()));
      wr_coef(1'b1, 3'(i), i == 0 ? 27'h20000 : i == 7 ? 27'h1ffff : 27'($urandom()));
    end

    // R10: latency of each copy
    mode = 2'd0; pre_en = 1'b0; coef_en = 1'b0; acc_en = 1'b0; acc_dbl = 1'b0;
    x_in = '0; y_in = '0; z_in = '0;
    repeat (3) @(negedge clk);
    x_in[26:0] = 27'd3; y_in[26:0] = 27'd5;
    @(negedge clk);
    check(res_b, 74'd15, "R10 bypassed copy after one cycle");
    check(res_m, 74'd0,  "R10 registered copy not yet updated");
    @(negedge clk);
    check(res_m, 74'd15, "R10 registered copy after two cycles");

    run_full(1500, 1'b0, 1'b0, 0, "R2");
    run_full(500,  1'b1, 1'b0, 0, "R5");
    run_full(400,  1'b0, 1'b1, 0, "R6");
    run_full(600,  1'b0, 1'b0, 1, "R7");
    run_full(600,  1'b1, 1'b1, 2, "R9");

    // R8: 4096 steps of 2^52 wrap the sum to zero
    mode = 2'd0; pre_en = 1'b0; coef_en = 1'b0; acc_dbl = 1'b0;
    for (int i = 0; i < 4096; i++) begin
      tick();
      x_in[26:0] = MIN27; y_in[26:0] = MIN27; acc_en = (i != 0);
      expect1("R8");
    end
    check(74'(m1), 74'd0, "R8 expected wrapped total");
    flush();

    run_dual(800, 1'b1, 1'b0, 1'b0, "R3");
    run_dual(800, 1'b0, 1'b0, 1'b0, "R3");
    run_dual(500, 1'b1, 1'b1, 1'b0, "R5");
    run_dual(500, 1'b0, 1'b0, 1'b1, "R6");

    // R4: every pair of 9-bit operands, spread over the three lanes
    mode = 2'd2; x_signed = 1'b1; pre_en = 1'b0; coef_en = 1'b0;
    for (int i = 0; i < 512; i++) begin
      for (int j = 0; j < 171; j++) begin
        tick();
        x_in = {9'(i), 9'(i), 9'(i), 9'(i)};
        y_in = {2'b00, 9'(j + 171), 9'(j + 342), 9'(j + 171), 9'(j)};
        expect1("R4");
      end
    end
    flush();
    run_tri(1500, 1'b0, 1'b0, 1'b0, "R4");
    run_tri(500,  1'b1, 1'b1, 1'b0, "R5");
    run_tri(500,  1'b1, 1'b0, 1'b1, "R6");

    // R11: clock enable low freezes both copies
    mode = 2'd0; pre_en = 1'b0; coef_en = 1'b0;
    @(negedge clk);
    ce = 1'b0;
    snap_m = res_m; snap_b = res_b;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(res_m, snap_m, "R11 registered copy holds");
      check(res_b, snap_b, "R11 bypassed copy holds");
      x_in = 36'(rnd()); y_in = 38'(rnd()); acc_en = 1'($urandom()); mode = 2'($urandom());
    end
    ce = 1'b1;
    run_full(50, 1'b0, 1'b0, 1, "R11 resume");

    finish_up();
  end
endmodule